// File: doc/BRIEF.md
# Bit-Serial Shared-Wire Layer Link

This block carries parallel words between a stack of processing levels that share a single one-bit vertical line. Each level owns a cell with a transmit shift register, a receive shift register, a holding register for the last received word and a tri-state driver onto the shared line. A controller accepts a transfer command that names one source level and a bit mask of destination levels.

An accepted command loads the source word into the source cell's transmit register in one cycle. The word is then shifted onto the line one bit per clock, most significant bit first. Only the source cell drives the line, and every other cell's driver is released to high impedance. Each level selected in the mask shifts the line in and, on the final bit, commits the rebuilt word to its holding register. A one-cycle done pulse follows. Commands that cannot form a legal transfer are refused with a one-cycle error pulse.

The block is used by a sequencer that loads the per-level words, issues a command, waits for the done pulse and reads the destination words.

Top module: `bsl_link`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, busy, done and err are 0, no driver is enabled and every received word is 0.
- R2: For an accepted command, the line carries the source word most significant bit first. Bit WORD_W-1-k is present in the (k+2)-th cycle after the cycle in which start was sampled, for k = 0 .. WORD_W-1.
- R3: At most one bit of drv_en is set in any cycle. While a bit is set, the line holds a known value and that bit is the source level.
- R4: busy rises in the cycle after an accepted start and stays high for WORD_W+1 cycles. done is high for exactly one cycle, in the cycle in which busy falls.
- R5: When done is high, every level whose mask bit is set holds the source word on rx_words.
- R6: A single transfer delivers the word to every selected level at once, for example one source to two destinations.
- R7: Levels whose mask bit is clear keep their previous received word through the transfer.
- R8: A start with an all-zero destination mask raises err for one cycle and starts no transfer.
- R9: A start whose destination mask includes the source level raises err for one cycle and starts no transfer.
- R10: A start whose source index is NUM_LVL or greater raises err for one cycle and starts no transfer.
- R11: A start presented while busy is high is ignored: it raises no err and does not alter the running transfer or any received word.
- R12: A start presented in the cycle in which done is high is accepted, and busy rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transfer request, sampled while the link is idle |
| src_sel | input | LVL_W | Index of the source level |
| dst_mask | input | NUM_LVL | One bit per destination level |
| tx_words | input | NUM_LVL x WORD_W | Word offered by each level for sending |
| rx_words | output | NUM_LVL x WORD_W | Last word received by each level |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last bit is captured |
| err | output | 1 | One-cycle pulse for a refused command |
| drv_en | output | NUM_LVL | Driver enable of each level onto the line |
| line_bit | output | 1 | Resolved value of the shared line |

## Verification
After a start is sampled, busy is due one cycle later. The line carries the first bit two cycles later and the last bit WORD_W+1 cycles later, and done and the committed words appear WORD_W+2 cycles later. A refused command shows err one cycle after the start. The bench drives inputs on falling edges and samples outputs at the following falling edge. It walks the cycles of a transfer one by one and checks each bit on the line and the driver mask at its exact cycle, then the done pulse, the busy drop and all received words. Ignored and refused starts are checked through err, busy and the received words on the ports.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } xfer_st_e;

    // A command is refused when the source is out of range, when no level is
    // selected, or when the source would receive its own word.
    function automatic logic cmd_bad(input int src, input int n_lvl,
                                     input logic [31:0] mask);
        logic bad;
        bad = (src >= n_lvl) || (mask == 32'd0);
        if (!bad && mask[src])
            bad = 1'b1;
        return bad;
    endfunction

endpackage

// File: rtl/bsl_ctrl.sv
module bsl_ctrl
    import bsl_pkg::*;
#(
    parameter int NUM_LVL = 5,
    parameter int WORD_W  = 16,
    localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int CNT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [LVL_W-1:0]   src_sel,
    input  logic [NUM_LVL-1:0] dst_mask,
    output logic [NUM_LVL-1:0] load_en,
    output logic [NUM_LVL-1:0] drive_en,
    output logic [NUM_LVL-1:0] cap_en,
    output logic [NUM_LVL-1:0] commit_en,
    output logic               busy,
    output logic               done,
    output logic               err
);

    xfer_st_e           st;
    logic [CNT_W-1:0]   cnt;
    logic [LVL_W-1:0]   src_q;
    logic [NUM_LVL-1:0] dst_q;
    logic [NUM_LVL-1:0] src_oh;
    logic               done_q;
    logic               err_q;
    logic               req_bad;
    logic               req_take;
    logic               req_drop;
    logic               last_bit;

    always_comb begin
        req_bad  = cmd_bad(int'(src_sel), NUM_LVL, 32'(dst_mask));
        req_take = (st == ST_IDLE) && start && !req_bad;
        req_drop = (st == ST_IDLE) && start && req_bad;
        last_bit = (st == ST_SHIFT) && (cnt == CNT_W'(WORD_W - 1));
    end

    always_comb begin
        src_oh = '0;
        for (int i = 0; i < NUM_LVL; i++)
            src_oh[i] = (src_q == LVL_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= req_drop;
            case (st)
                ST_IDLE: begin
                    if (req_take) begin
                        st    <= ST_LOAD;
                        src_q <= src_sel;
                        dst_q <= dst_mask;
                    end
                end
                ST_LOAD: begin
                    st  <= ST_SHIFT;
                    cnt <= '0;
                end
                ST_SHIFT: begin
                    if (last_bit) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign load_en   = (st == ST_LOAD)  ? src_oh : '0;
    assign drive_en  = (st == ST_SHIFT) ? src_oh : '0;
    assign cap_en    = (st == ST_SHIFT) ? dst_q  : '0;
    assign commit_en = last_bit         ? dst_q  : '0;
    assign busy      = (st != ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;

endmodule

// File: rtl/bsl_cell.sv
module bsl_cell #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              drive,
    input  logic              cap,
    input  logic              commit,
    input  logic [WORD_W-1:0] par_in,
    input  logic              line_in,
    output logic              drv_on,
    output logic              drv_bit,
    output logic [WORD_W-1:0] word_out
);

    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] rx_next;

    assign rx_next = {rx_sh[WORD_W-2:0], line_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh    <= '0;
            rx_sh    <= '0;
            word_out <= '0;
        end else begin
            if (load)
                tx_sh <= par_in;
            else if (drive)
                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            if (cap)
                rx_sh <= rx_next;
            if (commit)
                word_out <= rx_next;
        end
    end

    assign drv_on  = drive;
    assign drv_bit = tx_sh[WORD_W-1];

endmodule

// File: rtl/bsl_link.sv
module bsl_link #(
    parameter int NUM_LVL = 5,
    parameter int WORD_W  = 16,
    localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic [LVL_W-1:0]                src_sel,
    input  logic [NUM_LVL-1:0]              dst_mask,
    input  logic [NUM_LVL-1:0][WORD_W-1:0]  tx_words,
    output logic [NUM_LVL-1:0][WORD_W-1:0]  rx_words,
    output logic                            busy,
    output logic                            done,
    output logic                            err,
    output logic [NUM_LVL-1:0]              drv_en,
    output logic                            line_bit
);

    logic [NUM_LVL-1:0] load_en;
    logic [NUM_LVL-1:0] drive_en;
    logic [NUM_LVL-1:0] cap_en;
    logic [NUM_LVL-1:0] commit_en;
    logic [NUM_LVL-1:0] cell_bit;
    wire                vline;

    bsl_ctrl #(.NUM_LVL(NUM_LVL), .WORD_W(WORD_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .src_sel   (src_sel),
        .dst_mask  (dst_mask),
        .load_en   (load_en),
        .drive_en  (drive_en),
        .cap_en    (cap_en),
        .commit_en (commit_en),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        bsl_cell #(.WORD_W(WORD_W)) cell_i (
            .clk      (clk),
            .rst      (rst),
            .load     (load_en[g]),
            .drive    (drive_en[g]),
            .cap      (cap_en[g]),
            .commit   (commit_en[g]),
            .par_in   (tx_words[g]),
            .line_in  (vline),
            .drv_on   (drv_en[g]),
            .drv_bit  (cell_bit[g]),
            .word_out (rx_words[g])
        );
        // each level's tri-state driver onto the shared vertical line
        assign vline = drv_en[g] ? cell_bit[g] : 1'bz;
    end

    assign line_bit = vline;

endmodule

// File: rtl/bsl_link_chk.sv
module bsl_link_chk #(
    parameter int NUM_LVL = 5,
    parameter int WORD_W  = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           busy,
    input logic                           done,
    input logic                           err,
    input logic [NUM_LVL-1:0]             drv_en,
    input logic                           line_bit,
    input logic [NUM_LVL-1:0][WORD_W-1:0] rx_words
);

    a_r3_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_en));

    a_r3_line_known: assert property (@(posedge clk) disable iff (rst)
        (|drv_en) |-> !$isunknown(line_bit));

    a_r3_no_drive_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (drv_en == '0));

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r8_err_no_xfer: assert property (@(posedge clk) disable iff (rst)
        err |=> !busy);

    a_r7_words_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rx_words));

endmodule

bind bsl_link bsl_link_chk #(.NUM_LVL(NUM_LVL), .WORD_W(WORD_W)) chk_i (.*);

// File: tb/bsl_link_tb_top.sv
module bsl_link_tb_top;

    localparam int NL = 5;
    localparam int WW = 16;
    localparam int LW = 3;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   start;
    logic [LW-1:0]          src_sel;
    logic [NL-1:0]          dst_mask;
    logic [NL-1:0][WW-1:0]  tx_words;
    logic [NL-1:0][WW-1:0]  rx_words;
    logic                   busy;
    logic                   done;
    logic                   err;
    logic [NL-1:0]          drv_en;
    logic                   line_bit;

    logic [NL-1:0][WW-1:0]  exp_rx;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bsl_link #(.NUM_LVL(NL), .WORD_W(WW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .src_sel(src_sel),
        .dst_mask(dst_mask), .tx_words(tx_words), .rx_words(rx_words),
        .busy(busy), .done(done), .err(err), .drv_en(drv_en),
        .line_bit(line_bit)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_words(input string req);
        chk(rx_words === exp_rx, req, "rx_words", 128'(rx_words), 128'(exp_rx));
    endtask

    // Entered at a falling edge; ends at the falling edge where done is due.
    task automatic run_xfer(input int src, input logic [NL-1:0] mask,
                            input bit inject, input string req);
        logic [WW-1:0] w;
        w = tx_words[src];
        start = 1'b1; src_sel = LW'(src); dst_mask = mask;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R4", "busy after start", 128'(busy), 128'd1);
        for (int k = 0; k < WW; k++) begin
            @(negedge clk);
            chk(line_bit === w[WW-1-k], "R2", "serial bit", 128'(line_bit),
                128'(w[WW-1-k]));
            chk(drv_en === NL'(1 << src), "R3", "driver mask", 128'(drv_en),
                128'(1 << src));
            chk(busy === 1'b1 && err === 1'b0, "R4", "busy during shift",
                128'({busy, err}), 128'd2);
            if (inject && k == 4) begin
                start = 1'b1; src_sel = LW'((src + 1) % NL); dst_mask = NL'(1 << src);
            end
            if (inject && k == 5) begin
                chk(err === 1'b0, "R11", "no err on busy start", 128'(err), 128'd0);
                start = 1'b0;
            end
        end
        @(negedge clk);
        for (int i = 0; i < NL; i++)
            if (mask[i]) exp_rx[i] = w;
        chk(done === 1'b1 && busy === 1'b0, "R4", "done pulse", 128'({done, busy}),
            128'd2);
        chk_words(req);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; src_sel = '0; dst_mask = '0;
        tx_words = '0; exp_rx = '0;
        repeat (3) @(negedge clk);
        chk(busy === 0 && done === 0 && err === 0 && drv_en === '0, "R1",
            "flags in reset", 128'({busy, done, err, drv_en}), 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 0 && done === 0 && err === 0 && drv_en === '0, "R1",
            "flags after reset", 128'({busy, done, err, drv_en}), 128'd0);
        chk_words("R1");
    endtask

    task automatic t_single;
        tx_words[1] = 16'hA5C3;
        run_xfer(1, 5'b01000, 1'b0, "R5");
        @(negedge clk);
        chk(done === 1'b0, "R4", "done one cycle", 128'(done), 128'd0);
        chk_words("R7");
        tx_words[4] = 16'h8001;
        run_xfer(4, 5'b00001, 1'b0, "R5");
        @(negedge clk);
        chk_words("R7");
    endtask

    task automatic t_multi;
        tx_words[1] = 16'h3C96;
        run_xfer(1, 5'b11000, 1'b0, "R6");
        @(negedge clk);
        tx_words[0] = 16'hFFFF;
        run_xfer(0, 5'b10110, 1'b0, "R6");
        @(negedge clk);
        chk_words("R7");
    endtask

    task automatic t_refuse(input int src, input logic [NL-1:0] mask,
                            input string req);
        start = 1'b1; src_sel = LW'(src); dst_mask = mask;
        @(negedge clk);
        start = 1'b0;
        chk(err === 1'b1 && busy === 1'b0, req, "err pulse", 128'({err, busy}),
            128'd2);
        @(negedge clk);
        chk(err === 1'b0 && busy === 1'b0 && drv_en === '0, req, "no transfer",
            128'({err, busy, drv_en}), 128'd0);
        repeat (2) @(negedge clk);
        chk(done === 1'b0, req, "no done", 128'(done), 128'd0);
        chk_words(req);
    endtask

    task automatic t_busy_start;
        tx_words[2] = 16'h1234;
        tx_words[3] = 16'hBEEF;
        run_xfer(2, 5'b00010, 1'b1, "R11");
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R11", "ignored start idle",
            128'({busy, done}), 128'd0);
        repeat (WW + 4) @(negedge clk);
        chk_words("R11");
    endtask

    task automatic t_back_to_back;
        tx_words[0] = 16'h5A5A;
        tx_words[3] = 16'h0F0F;
        run_xfer(0, 5'b00100, 1'b0, "R5");
        // still in the done cycle: issue the next command here
        run_xfer(3, 5'b10001, 1'b0, "R12");
        @(negedge clk);
        chk(busy === 1'b0, "R12", "idle after chain", 128'(busy), 128'd0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_refuse(2, 5'b00000, "R8");
        t_refuse(3, 5'b01001, "R9");
        t_refuse(6, 5'b00010, "R10");
        t_busy_start();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule